// File: doc/BRIEF.md
# Half-Rate DDR3 Command Launcher

This block sits between a memory controller whose logic runs at half the memory clock rate and the DDR3 command and address pins, which run at single data rate on the full-rate memory clock. Each core clock cycle spans two memory command slots. The block presents both slots side by side as two-bit vectors, and the physical output stage serialises them with slot 0 first. The core hands over one command per core cycle through a valid/ready handshake. The command is ACTIVATE, READ, WRITE, PRECHARGE, REFRESH or an explicit NOP, with its bank, row or column, options and a choice of the early or late slot.

The block turns the operation into the chip-select/row/column/write-enable pin pattern. It places row or column and option bits on the shared address pins. It then shapes the pulses. The chip select and on-die termination are driven for exactly one memory slot. The command pins, bank and address are held for two consecutive slots. A late-slot command therefore spills into the early slot of the next core cycle, and the block stops accepting commands for that one cycle. Clock enable follows a request input through one register. No command is accepted while it is low.

Top module: `ddr3c_cmd_launch`

## Requirements
- R1: During and after reset, both slots show chip select high, row/column/write-enable pins high, bank and address zero, termination low, clock enable low; `cmd_ready` is low.
- R2: The pin pattern {RAS_N,CAS_N,WE_N} in the command slot, with CS_N low, is 3'b011 for ACTIVATE (`cmd_op`=1), 3'b101 for READ (2), 3'b100 for WRITE (3), 3'b010 for PRECHARGE (4), 3'b001 for REFRESH (5) and 3'b111 for NOP (0).
- R3: A command accepted at a core clock edge appears in the outputs registered at that edge, in bit 0 of every pin vector when `cmd_late`=0 and in bit 1 when `cmd_late`=1. Bit 0 is the earlier memory slot.
- R4: Each accepted command drives CS_N low in exactly one memory slot. No two adjacent memory slots have CS_N low together.
- R5: RAS_N, CAS_N, WE_N, BA and A keep the command's values for two consecutive memory slots. For an early-slot command the second slot is bit 1 of the same core cycle. For a late-slot command it is bit 0 of the next core cycle. CS_N is high in the second slot.
- R6: ACTIVATE drives BA with `cmd_bank` and A with `cmd_row`.
- R7: READ and WRITE drive BA with the bank and A[9:0] with the column. A10 is the auto-precharge flag and A12 is 1 for burst length 8 and 0 for burst chop 4. All other address bits are 0.
- R8: PRECHARGE drives BA with the bank, A10 with the all-banks flag and other address bits 0. REFRESH and NOP drive BA and A with zero.
- R9: ODT is high for exactly the command slot of an accepted WRITE with `cmd_odt`=1. `cmd_odt` has no effect on any other command.
- R10: Clock enable in both slots equals `cke_req` from the previous core edge. `cmd_ready` is low whenever that registered clock enable is low, and a request offered then is ignored.
- R11: For one core cycle after a late-slot command is accepted, `cmd_ready` is low and a request offered in that cycle is ignored.
- R12: A memory slot carrying neither a command nor its hold shows CS_N, RAS_N, CAS_N and WE_N high and BA and A zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate core clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_req | input | 1 | Requested clock-enable level |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_bank | input | 3 | Bank number |
| cmd_row | input | 16 | Row for ACTIVATE |
| cmd_col | input | COL_W | Starting column for READ/WRITE |
| cmd_auto_pre | input | 1 | Auto precharge after READ/WRITE |
| cmd_burst8 | input | 1 | 1: burst length 8, 0: burst chop 4 |
| cmd_all_banks | input | 1 | PRECHARGE targets all banks |
| cmd_late | input | 1 | 0: early slot, 1: late slot |
| cmd_odt | input | 1 | Request termination with a WRITE |
| mem_cke | output | 2 | Clock enable per slot |
| mem_cs_n | output | 2 | Chip select per slot |
| mem_ras_n | output | 2 | Row strobe per slot |
| mem_cas_n | output | 2 | Column strobe per slot |
| mem_we_n | output | 2 | Write enable per slot |
| mem_odt | output | 2 | On-die termination per slot |
| mem_ba | output | 6 | Bank per slot, slot 0 in [2:0] |
| mem_a | output | 32 | Address per slot, slot 0 in [15:0] |

## Verification
The embedded properties watch every cycle: chip select never falls in two adjacent memory slots, and command and address pins stay stable across the two slots of each command, including a hold that crosses a core clock edge. They also check that termination only rises in a command slot, that no request is taken while the spill-over slot is pending, and that readiness follows the registered clock enable. The exact pin pattern per operation, the address field placement, and the refusal of requests while ready is low can only be seen in the bench's scenarios. Those scenarios use directed late-slot sequences, clock-enable drops and a long seeded random stream compared against a bench model.

// File: rtl/ddr3c_pkg.sv
package ddr3c_pkg;

    localparam int BA_W = 3;
    localparam int A_W  = 16;
    localparam int AP_BIT = 10;
    localparam int BL_BIT = 12;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5
    } op_e;

    typedef struct packed {
        logic            cs_n;
        logic            ras_n;
        logic            cas_n;
        logic            we_n;
        logic [BA_W-1:0] ba;
        logic [A_W-1:0]  a;
    } pin_word_t;

    localparam int BODY_W = $bits(pin_word_t) - 1;

    localparam pin_word_t DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                       we_n: 1'b1, ba: '0, a: '0};

    function automatic logic [2:0] strobe_pattern(input op_e op);
        case (op)
            OP_ACT:  return 3'b011;
            OP_RD:   return 3'b101;
            OP_WR:   return 3'b100;
            OP_PRE:  return 3'b010;
            OP_REF:  return 3'b001;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/ddr3c_cmd_encode.sv
module ddr3c_cmd_encode
    import ddr3c_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]      op,
    input  logic [BA_W-1:0] bank,
    input  logic [A_W-1:0]  row,
    input  logic [COL_W-1:0] col,
    input  logic            auto_pre,
    input  logic            burst8,
    input  logic            all_banks,
    output pin_word_t       word,
    output logic            is_write
);

    op_e op_t;
    assign op_t = op_e'(op);

    always_comb begin
        word = DESELECT;
        word.cs_n = 1'b0;
        {word.ras_n, word.cas_n, word.we_n} = strobe_pattern(op_t);
        case (op_t)
            OP_ACT: begin
                word.ba = bank;
                word.a  = row;
            end
            OP_RD, OP_WR: begin
                word.ba = bank;
                for (int i = 0; i < COL_W; i++) word.a[i] = col[i];
                word.a[AP_BIT] = auto_pre;
                word.a[BL_BIT] = burst8;
            end
            OP_PRE: begin
                word.ba = bank;
                word.a[AP_BIT] = all_banks;
            end
            default: ;
        endcase
    end

    assign is_write = (op_t == OP_WR);

    always_comb begin
        assert (COL_W <= AP_BIT) else $error("a_r7_col_fits: column wider than A[9:0]");
    end

endmodule

// File: rtl/ddr3c_slot_pair.sv
module ddr3c_slot_pair
    import ddr3c_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  logic      late,
    input  pin_word_t word,
    input  logic      odt_req,
    output pin_word_t slot0,
    output pin_word_t slot1,
    output logic [1:0] odt,
    output logic      busy
);

    pin_word_t carry_q;
    pin_word_t n0, n1;
    logic [1:0] odt_n;

    always_comb begin
        n0 = DESELECT;
        n1 = DESELECT;
        odt_n = 2'b00;
        if (busy) begin
            n0 = carry_q;
            n0.cs_n = 1'b1;
        end
        if (fire && !late) begin
            n0 = word;
            n1 = word;
            n1.cs_n = 1'b1;
            odt_n[0] = odt_req;
        end
        if (fire && late) begin
            n1 = word;
            odt_n[1] = odt_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0   <= DESELECT;
            slot1   <= DESELECT;
            carry_q <= DESELECT;
            odt     <= 2'b00;
            busy    <= 1'b0;
        end else begin
            slot0 <= n0;
            slot1 <= n1;
            odt   <= odt_n;
            busy  <= fire && late;
            if (fire && late) carry_q <= word;
        end
    end

    a_r1_reset_deselect: assert property (@(posedge clk)
        rst |=> (slot0.cs_n && slot1.cs_n && odt == 2'b00));

    // R4: one select per command, never in two adjacent memory slots
    a_r4_early_alone: assert property (@(posedge clk) disable iff (rst)
        !slot0.cs_n |-> slot1.cs_n);
    a_r4_late_alone: assert property (@(posedge clk) disable iff (rst)
        !slot1.cs_n |=> slot0.cs_n);

    // R5: body held over two memory slots
    a_r5_hold_inside: assert property (@(posedge clk) disable iff (rst)
        !slot0.cs_n |-> slot1[BODY_W-1:0] == slot0[BODY_W-1:0]);
    a_r5_hold_across: assert property (@(posedge clk) disable iff (rst)
        !slot1.cs_n |=> slot0[BODY_W-1:0] == $past(slot1[BODY_W-1:0]));

    a_r9_odt_in_cmd_slot: assert property (@(posedge clk) disable iff (rst)
        (odt[0] |-> !slot0.cs_n) and (odt[1] |-> !slot1.cs_n));

    a_r11_no_fire_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fire);

endmodule

// File: rtl/ddr3c_cke_gate.sv
module ddr3c_cke_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke_req,
    input  logic busy,
    output logic cke_q,
    output logic ready
);

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b0;
        else     cke_q <= cke_req;
    end

    assign ready = cke_q && !busy;

    a_r1_reset_cke_low: assert property (@(posedge clk)
        rst |=> !cke_q);

    a_r10_ready_follows_req: assert property (@(posedge clk) disable iff (rst)
        !cke_req |=> !ready);

endmodule

// File: rtl/ddr3c_cmd_launch.sv
module ddr3c_cmd_launch
    import ddr3c_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_req,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [BA_W-1:0]   cmd_bank,
    input  logic [A_W-1:0]    cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_auto_pre,
    input  logic              cmd_burst8,
    input  logic              cmd_all_banks,
    input  logic              cmd_late,
    input  logic              cmd_odt,
    output logic [1:0]        mem_cke,
    output logic [1:0]        mem_cs_n,
    output logic [1:0]        mem_ras_n,
    output logic [1:0]        mem_cas_n,
    output logic [1:0]        mem_we_n,
    output logic [1:0]        mem_odt,
    output logic [2*BA_W-1:0] mem_ba,
    output logic [2*A_W-1:0]  mem_a
);

    pin_word_t word, s0, s1;
    logic is_write, busy, cke_q, fire;

    ddr3c_cmd_encode #(.COL_W(COL_W)) u_encode (
        .op        (cmd_op),
        .bank      (cmd_bank),
        .row       (cmd_row),
        .col       (cmd_col),
        .auto_pre  (cmd_auto_pre),
        .burst8    (cmd_burst8),
        .all_banks (cmd_all_banks),
        .word      (word),
        .is_write  (is_write)
    );

    ddr3c_cke_gate u_cke (
        .clk     (clk),
        .rst     (rst),
        .cke_req (cke_req),
        .busy    (busy),
        .cke_q   (cke_q),
        .ready   (cmd_ready)
    );

    assign fire = cmd_valid && cmd_ready;

    ddr3c_slot_pair u_slots (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .late    (cmd_late),
        .word    (word),
        .odt_req (cmd_odt && is_write),
        .slot0   (s0),
        .slot1   (s1),
        .odt     (mem_odt),
        .busy    (busy)
    );

    assign mem_cke   = {cke_q, cke_q};
    assign mem_cs_n  = {s1.cs_n,  s0.cs_n};
    assign mem_ras_n = {s1.ras_n, s0.ras_n};
    assign mem_cas_n = {s1.cas_n, s0.cas_n};
    assign mem_we_n  = {s1.we_n,  s0.we_n};
    assign mem_ba    = {s1.ba, s0.ba};
    assign mem_a     = {s1.a,  s0.a};

endmodule

// File: tb/test_ddr3c_cmd_launch.sv
`timescale 1ns/1ps
module test_ddr3c_cmd_launch;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cke_req, cmd_valid, cmd_ready;
    logic [2:0] cmd_op, cmd_bank;
    logic [15:0] cmd_row;
    logic [9:0] cmd_col;
    logic cmd_auto_pre, cmd_burst8, cmd_all_banks, cmd_late, cmd_odt;
    logic [1:0] mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_odt;
    logic [5:0] mem_ba;
    logic [31:0] mem_a;

    ddr3c_cmd_launch #(.COL_W(10)) i_ddr3c_cmd_launch (
        .clk(clk), .rst(rst), .cke_req(cke_req), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_auto_pre(cmd_auto_pre),
        .cmd_burst8(cmd_burst8), .cmd_all_banks(cmd_all_banks),
        .cmd_late(cmd_late), .cmd_odt(cmd_odt), .mem_cke(mem_cke),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_odt(mem_odt), .mem_ba(mem_ba), .mem_a(mem_a)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag;

    localparam logic [22:0] IDLE_W = {4'b1111, 3'b000, 16'h0000};

    // expected state: word = {cs,ras,cas,we,ba[2:0],a[15:0]}
    logic [22:0] e_w0, e_w1, car_w;
    logic [1:0]  e_odt;
    logic        e_cke, e_ready, car;

    function automatic logic [22:0] enc(input logic [2:0] op, input logic [2:0] bk,
                                        input logic [15:0] row, input logic [9:0] col,
                                        input logic ap, input logic b8, input logic ab);
        logic [2:0] p;
        logic [2:0] ba;
        logic [15:0] a;
        ba = 3'd0; a = 16'd0;
        case (op)
            3'd1: begin p = 3'b011; ba = bk; a = row; end
            3'd2: begin p = 3'b101; ba = bk; a = {3'b000, b8, 1'b0, ap, col}; end
            3'd3: begin p = 3'b100; ba = bk; a = {3'b000, b8, 1'b0, ap, col}; end
            3'd4: begin p = 3'b010; ba = bk; a = 16'h0400 & {16{ab}}; end
            3'd5: p = 3'b001;
            default: p = 3'b111;
        endcase
        return {1'b0, p, ba, a};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 cs_n",        {30'd0, mem_cs_n}, {30'd0, e_w1[22], e_w0[22]});
        chk("R2 ras/cas/we",  {26'd0, mem_ras_n[1], mem_cas_n[1], mem_we_n[1],
                               mem_ras_n[0], mem_cas_n[0], mem_we_n[0]},
                              {26'd0, e_w1[21:19], e_w0[21:19]});
        chk("R5 R6 bank",     {26'd0, mem_ba}, {26'd0, e_w1[18:16], e_w0[18:16]});
        chk("R5 R6 address",  mem_a, {e_w1[15:0], e_w0[15:0]});
        chk("R9 odt",         {30'd0, mem_odt}, {30'd0, e_odt});
        chk("R10 cke",        {30'd0, mem_cke}, {30'd0, e_cke, e_cke});
        chk("R10 ready",      {31'd0, cmd_ready}, {31'd0, e_ready});
    endtask

    // one core cycle: check current outputs, then drive and predict
    task automatic step(input logic v, input logic [2:0] op, input logic [2:0] bk,
                        input logic [15:0] row, input logic [9:0] col,
                        input logic ap, input logic b8, input logic ab,
                        input logic late, input logic odt, input logic ck);
        logic acc;
        logic [22:0] w, n0, n1;
        logic [1:0] no;
        @(negedge clk);
        compare_all();
        cmd_valid = v; cmd_op = op; cmd_bank = bk; cmd_row = row; cmd_col = col;
        cmd_auto_pre = ap; cmd_burst8 = b8; cmd_all_banks = ab; cmd_late = late;
        cmd_odt = odt; cke_req = ck;
        acc = v && e_ready;
        w = enc(op, bk, row, col, ap, b8, ab);
        n0 = IDLE_W; n1 = IDLE_W; no = 2'b00;
        if (car) n0 = {1'b1, car_w[21:0]};
        if (acc && !late) begin
            n0 = w; n1 = {1'b1, w[21:0]}; no[0] = odt && (op == 3'd3);
        end
        if (acc && late) begin
            n1 = w; no[1] = odt && (op == 3'd3);
        end
        car = acc && late;
        if (car) car_w = w;
        e_w0 = n0; e_w1 = n1; e_odt = no; e_cke = ck;
        e_ready = ck && !car;
    endtask

    task automatic idle(input logic ck);
        step(1'b0, 3'd0, 3'd0, 16'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ck);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd4242;
        void'($urandom(seed));
        rst = 1'b1; cke_req = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 3'd0;
        cmd_row = 16'd0; cmd_col = 10'd0; cmd_auto_pre = 1'b0; cmd_burst8 = 1'b0;
        cmd_all_banks = 1'b0; cmd_late = 1'b0; cmd_odt = 1'b0;
        e_w0 = IDLE_W; e_w1 = IDLE_W; car_w = IDLE_W; e_odt = 2'b00;
        e_cke = 1'b0; e_ready = 1'b0; car = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        compare_all();
        rst = 1'b0;

        tag = "R10 cke low ignores request";
        step(1'b1, 3'd1, 3'd5, 16'hBEEF, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(1'b1);

        tag = "R3 early activate";
        step(1'b1, 3'd1, 3'd6, 16'hA5C3, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        tag = "R5 R11 late write with odt";
        step(1'b1, 3'd3, 3'd2, 16'd0, 10'h2AB, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        tag = "R11 request during spill is ignored";
        step(1'b1, 3'd2, 3'd7, 16'd0, 10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        tag = "R7 read chop4 auto precharge";
        step(1'b1, 3'd2, 3'd1, 16'd0, 10'h155, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        tag = "R8 precharge all banks";
        step(1'b1, 3'd4, 3'd3, 16'hFFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        idle(1'b1);
        tag = "R8 refresh";
        step(1'b1, 3'd5, 3'd7, 16'hFFFF, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        tag = "R9 odt ignored for read";
        step(1'b1, 3'd2, 3'd4, 16'd0, 10'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        tag = "R2 nop with select";
        step(1'b1, 3'd0, 3'd0, 16'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        tag = "R12 idle slots";
        idle(1'b1);
        idle(1'b1);
        tag = "R10 cke drop";
        idle(1'b0);
        step(1'b1, 3'd1, 3'd1, 16'h1234, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle(1'b1);

        tag = "random R2 R3 R4 R5 R6 R7 R8 R9";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, 3'($urandom % 6), 3'($urandom), 16'($urandom),
                 10'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 20) != 0);
        end
        idle(1'b1);
        idle(1'b1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule